// File: doc/BRIEF.md
# Differential Clock Output Park Controller

This block decides, cycle by cycle, what each differential clock output lane does: toggle normally, park with its true side held high at the strong stop current, park low at the weak power-down current, or float. It takes an asynchronous power-down pin (active high) and an asynchronous stop pin (active low). Each lane also has four control bits: output enable, power-down float, stop float and free-running. A 96 MHz differential output has its own enable and power-down float bit.

Both pins pass through a synchronizer before they affect any lane. A power sequencer parks every lane low before it raises the oscillator-off flag. When power-down is released, a stabilization counter holds the lanes parked until it expires. Each lane has a small state machine. It parks a stoppable lane only on a rising transition of its level, and it brings the lane back after a fixed number of cycles once the stop is released. The lanes can never produce a runt pulse.

The outputs are a 2-bit mode code per lane (0 run, 1 parked high at strong current, 2 parked low at weak current, 3 float), the true-side level per lane, the 96 MHz output mode in the same code, a single-ended force-low flag and an oscillator-off flag. A consumer maps these codes onto its current sources and tristate controls.

Top module: `diffclk_park_ctrl`

## Requirements
- R1: A lane whose output enable bit is 0 reports mode 3 (float), whatever its other bits and both pins are.
- R2: With the power-down pin low and the stop pin high, an enabled lane reports mode 0 (run), and its level toggles every clock cycle.
- R3: With the stop pin low and power-down low, a free-running lane reports mode 0. A stoppable lane reports mode 1 with level 1 if its stop-float bit is 0, or mode 3 if that bit is 1.
- R4: While power-down holds, every enabled lane reports mode 2 with level 0 if its power-down float bit is 0, or mode 3 if that bit is 1. This holds whether the lane is free-running or stoppable and whatever the stop pin does.
- R5: Both pins pass through a two-flop synchronizer. A stoppable lane still runs 2 edges after the stop pin falls and is parked by the 4th edge. It enters mode 1 only on a transition of its level from 0 to 1.
- R6: After the stop pin rises, a parked lane returns to mode 0 exactly RESUME_LAT+3 edges later (RESUME_LAT is limited to 2..6). Its first running cycle has level 1.
- R7: On power-down assertion, lanes switch to mode 2 or 3 on the 3rd edge after the pin rises. The oscillator-off flag rises one edge later, never before all lanes are parked.
- R8: On power-down release, the oscillator-off flag clears on the 3rd edge. The lanes stay parked for STAB_CYCLES further edges and then run.
- R9: The single-ended force-low flag is 1 exactly while the lanes are held parked by power-down or stabilization.
- R10: The 96 MHz output reports mode 3 when its enable is 0. Under power-down it reports mode 2, or mode 3 if its power-down float bit is 1. Otherwise it reports mode 0.
- R11: After reset, every enabled lane reports mode 0 with level 0, and the oscillator-off flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pd_i | input | 1 | Power-down pin, active high, asynchronous |
| stop_n_i | input | 1 | Stop pin, active low, asynchronous |
| dot_oe_i | input | 1 | 96 MHz output enable |
| dot_pd_tri_i | input | 1 | 96 MHz output floats in power-down when 1 |
| oe_i | input | N_LANES | Per-lane output enable |
| pd_tri_i | input | N_LANES | Per-lane float in power-down |
| stop_tri_i | input | N_LANES | Per-lane float when stopped |
| free_run_i | input | N_LANES | Per-lane ignore-stop bit |
| mode_o | output | 2*N_LANES | Per-lane mode code, lane i at bits 2i+1:2i |
| lvl_o | output | N_LANES | Per-lane true-side level |
| dot_mode_o | output | 2 | 96 MHz output mode code |
| se_low_o | output | 1 | Force single-ended outputs low |
| osc_off_o | output | 1 | Oscillator shut-off flag |

## Verification
The bench uses N_LANES=3, RESUME_LAT=3 and STAB_CYCLES=8, keeping the synchronizer default of two stages. A stabilization window of eight edges lets one table step cover a full power-down release. The exact edge on which lanes return to running can then be checked on both sides. A resume latency of three places the return on a known edge, so both the still-parked sample and the first running sample can be checked. Three lanes driven with identical bits show that the per-lane logic repeats without cross-talk.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

   typedef enum logic [1:0] {
      LM_RUN     = 2'd0,
      LM_PARK_HI = 2'd1,
      LM_PARK_LO = 2'd2,
      LM_FLOAT   = 2'd3
   } lane_mode_e;

   typedef enum logic [1:0] {
      LS_RUN    = 2'd0,
      LS_PARKED = 2'd1,
      LS_RESUME = 2'd2
   } lane_st_e;

   typedef enum logic [1:0] {
      PS_ON    = 2'd0,
      PS_DRAIN = 2'd1,
      PS_OFF   = 2'd2,
      PS_WARM  = 2'd3
   } pwr_st_e;

endpackage

// File: rtl/dcs_sync.sv
module dcs_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stg[k] <= '0;
      end else begin
         stg[0] <= d;
         for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/dcs_pwr_seq.sv
module dcs_pwr_seq
   import dcs_pkg::*;
#(
   parameter int STAB_CYCLES = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pd_s,
   output logic hold,
   output logic osc_off
);

   localparam int CW = $clog2(STAB_CYCLES + 1);

   pwr_st_e       st;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= PS_ON;
         cnt <= '0;
      end else begin
         case (st)
            PS_ON:    if (pd_s) st <= PS_DRAIN;
            PS_DRAIN: st <= PS_OFF;
            PS_OFF: begin
               if (!pd_s) begin
                  st  <= PS_WARM;
                  cnt <= '0;
               end
            end
            PS_WARM: begin
               if (pd_s)                                st  <= PS_DRAIN;
               else if (cnt == CW'(STAB_CYCLES - 1))    st  <= PS_ON;
               else                                     cnt <= cnt + 1'b1;
            end
            default: st <= PS_ON;
         endcase
      end
   end

   assign hold    = (st != PS_ON);
   assign osc_off = (st == PS_OFF);

endmodule

// File: rtl/dcs_lane.sv
module dcs_lane
   import dcs_pkg::*;
#(
   parameter int RESUME_LAT = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       stop_s,
   input  logic       pd_hold,
   input  logic       oe,
   input  logic       pd_tri,
   input  logic       stop_tri,
   input  logic       free_run,
   output lane_mode_e mode,
   output logic       lvl
);

   localparam int CW = $clog2(RESUME_LAT + 1);

   lane_st_e      st;
   logic          phase;
   logic [CW-1:0] cnt;
   logic          stop_req;

   assign stop_req = stop_s && !free_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= LS_RUN;
         phase <= 1'b0;
         cnt   <= '0;
      end else if (pd_hold) begin
         st    <= LS_RUN;
         phase <= 1'b0;
         cnt   <= '0;
      end else begin
         case (st)
            LS_RUN: begin
               phase <= ~phase;
               if (stop_req && !phase) st <= LS_PARKED;
            end
            LS_PARKED: begin
               if (!stop_req) begin
                  st  <= LS_RESUME;
                  cnt <= '0;
               end
            end
            LS_RESUME: begin
               if (stop_req)                          st  <= LS_PARKED;
               else if (cnt == CW'(RESUME_LAT - 1))   st  <= LS_RUN;
               else                                   cnt <= cnt + 1'b1;
            end
            default: st <= LS_RUN;
         endcase
      end
   end

   always_comb begin
      if (!oe) begin
         mode = LM_FLOAT;
         lvl  = 1'b0;
      end else if (pd_hold) begin
         mode = pd_tri ? LM_FLOAT : LM_PARK_LO;
         lvl  = 1'b0;
      end else if (st != LS_RUN) begin
         mode = stop_tri ? LM_FLOAT : LM_PARK_HI;
         lvl  = 1'b1;
      end else begin
         mode = LM_RUN;
         lvl  = phase;
      end
   end

endmodule

// File: rtl/diffclk_park_ctrl.sv
module diffclk_park_ctrl
   import dcs_pkg::*;
#(
   parameter int N_LANES     = 3,
   parameter int RESUME_LAT  = 3,
   parameter int STAB_CYCLES = 1000,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 pd_i,
   input  logic                 stop_n_i,
   input  logic                 dot_oe_i,
   input  logic                 dot_pd_tri_i,
   input  logic [N_LANES-1:0]   oe_i,
   input  logic [N_LANES-1:0]   pd_tri_i,
   input  logic [N_LANES-1:0]   stop_tri_i,
   input  logic [N_LANES-1:0]   free_run_i,
   output logic [2*N_LANES-1:0] mode_o,
   output logic [N_LANES-1:0]   lvl_o,
   output logic [1:0]           dot_mode_o,
   output logic                 se_low_o,
   output logic                 osc_off_o
);

   generate
      if (N_LANES < 1) begin : g_bad_lanes
         $error("N_LANES must be at least 1");
      end
      if (RESUME_LAT < 2 || RESUME_LAT > 6) begin : g_bad_lat
         $error("RESUME_LAT must lie in 2..6");
      end
      if (STAB_CYCLES < 1) begin : g_bad_stab
         $error("STAB_CYCLES must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [1:0] pins_s;
   logic       pd_s;
   logic       stop_s;
   logic       pd_hold;

   dcs_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({pd_i, ~stop_n_i}),
      .q     (pins_s)
   );

   assign pd_s   = pins_s[1];
   assign stop_s = pins_s[0];

   dcs_pwr_seq #(.STAB_CYCLES(STAB_CYCLES)) u_pwr (
      .clk     (clk),
      .rst_n   (rst_n),
      .pd_s    (pd_s),
      .hold    (pd_hold),
      .osc_off (osc_off_o)
   );

   generate
      for (genvar i = 0; i < N_LANES; i++) begin : g_lane
         lane_mode_e lmode;
         dcs_lane #(.RESUME_LAT(RESUME_LAT)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .stop_s   (stop_s),
            .pd_hold  (pd_hold),
            .oe       (oe_i[i]),
            .pd_tri   (pd_tri_i[i]),
            .stop_tri (stop_tri_i[i]),
            .free_run (free_run_i[i]),
            .mode     (lmode),
            .lvl      (lvl_o[i])
         );
         assign mode_o[2*i +: 2] = lmode;
      end
   endgenerate

   always_comb begin
      if (!dot_oe_i)    dot_mode_o = LM_FLOAT;
      else if (pd_hold) dot_mode_o = dot_pd_tri_i ? LM_FLOAT : LM_PARK_LO;
      else              dot_mode_o = LM_RUN;
   end

   assign se_low_o = pd_hold;

endmodule

// File: rtl/dcs_checker.sv
module dcs_checker #(
   parameter int N_LANES = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [N_LANES-1:0]   oe_i,
   input logic [2*N_LANES-1:0] mode_o,
   input logic [N_LANES-1:0]   lvl_o,
   input logic                 se_low_o,
   input logic                 osc_off_o
);

   AST_DRAIN_BEFORE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(osc_off_o) |-> $past(se_low_o)); // R7

   generate
      for (genvar i = 0; i < N_LANES; i++) begin : g_chk
         AST_OE_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
            !oe_i[i] |-> (mode_o[2*i +: 2] == 2'd3)); // R1

         AST_PARK_HI_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_o[2*i +: 2] == 2'd1) |-> lvl_o[i]); // R3

         AST_OSC_OFF_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
            osc_off_o |-> (mode_o[2*i +: 2] != 2'd0)); // R4

         AST_PARK_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
            ((mode_o[2*i +: 2] == 2'd1) && ($past(mode_o[2*i +: 2]) == 2'd0))
               |-> (lvl_o[i] && !$past(lvl_o[i]))); // R5

         AST_RESUME_NO_RUNT: assert property (@(posedge clk) disable iff (!rst_n)
            ((mode_o[2*i +: 2] == 2'd0) && ($past(mode_o[2*i +: 2]) == 2'd1))
               |-> lvl_o[i]); // R6
      end
   endgenerate

endmodule

bind diffclk_park_ctrl dcs_checker #(.N_LANES(N_LANES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .oe_i      (oe_i),
   .mode_o    (mode_o),
   .lvl_o     (lvl_o),
   .se_low_o  (se_low_o),
   .osc_off_o (osc_off_o)
);

// File: tb/diffclk_park_ctrl_tb.sv
module diffclk_park_ctrl_tb;

   localparam int N  = 3;
   localparam int RL = 3;
   localparam int SC = 8;

   logic           clk = 1'b0;
   logic           rst_n;
   logic           pd_i, stop_n_i, dot_oe_i, dot_pd_tri_i;
   logic [N-1:0]   oe_i, pd_tri_i, stop_tri_i, free_run_i;
   logic [2*N-1:0] mode_o;
   logic [N-1:0]   lvl_o;
   logic [1:0]     dot_mode_o;
   logic           se_low_o, osc_off_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   diffclk_park_ctrl #(
      .N_LANES(N), .RESUME_LAT(RL), .STAB_CYCLES(SC), .SYNC_STAGES(2)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .pd_i(pd_i), .stop_n_i(stop_n_i),
      .dot_oe_i(dot_oe_i), .dot_pd_tri_i(dot_pd_tri_i),
      .oe_i(oe_i), .pd_tri_i(pd_tri_i), .stop_tri_i(stop_tri_i),
      .free_run_i(free_run_i), .mode_o(mode_o), .lvl_o(lvl_o),
      .dot_mode_o(dot_mode_o), .se_low_o(se_low_o), .osc_off_o(osc_off_o)
   );

   // [7] oe [6] pd_tri [5] stop_tri [4] free_run [3] pd pin [2] stop_n pin [1:0] mode
   localparam logic [7:0] VEC [12] = '{
      8'b1000_0100, 8'b1000_0001, 8'b1010_0011, 8'b1001_0000,
      8'b1010_1110, 8'b1100_1011, 8'b1101_1111, 8'b0001_0111,
      8'b0000_1011, 8'b1001_1010, 8'b1110_0100, 8'b1111_0000
   };

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input string what, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
      end
   endtask

   task automatic chk_lanes(input string req, input int exp);
      for (int l = 0; l < N; l++) chk(req, $sformatf("lane%0d mode", l), int'(mode_o[2*l +: 2]), exp);
   endtask

   task automatic set_bits(input logic oe, input logic pt, input logic st, input logic fr);
      oe_i       = {N{oe}};
      pd_tri_i   = {N{pt}};
      stop_tri_i = {N{st}};
      free_run_i = {N{fr}};
   endtask

   task automatic summary;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic       prev;
      logic [7:0] v;
      string      tag;
      rst_n = 1'b0; pd_i = 1'b0; stop_n_i = 1'b1;
      dot_oe_i = 1'b1; dot_pd_tri_i = 1'b0;
      set_bits(1'b1, 1'b0, 1'b0, 1'b0);
      step(3);
      // R11: reset state
      chk_lanes("R11", 0);
      chk("R11", "lvl", int'(lvl_o), 0);
      chk("R11", "osc_off", int'(osc_off_o), 0);
      rst_n = 1'b1;
      step(2);

      // table of steady-state priorities
      for (int r = 0; r < 12; r++) begin
         v = VEC[r];
         set_bits(v[7], v[6], v[5], v[4]);
         pd_i = v[3]; stop_n_i = v[2];
         step(16);
         if (!v[7])      tag = "R1";
         else if (v[3])  tag = "R4";
         else if (!v[2]) tag = "R3";
         else            tag = "R2";
         chk_lanes(tag, int'(v[1:0]));
         if (v[1:0] == 2'd1)      chk(tag, "lvl", int'(lvl_o[0]), 1);
         else if (v[1:0] == 2'd2) chk(tag, "lvl", int'(lvl_o[0]), 0);
         else if (v[1:0] == 2'd0) begin
            prev = lvl_o[0];
            step(1);
            chk(tag, "toggle", int'(lvl_o[0]), int'(!prev));
         end
      end

      // R5: stop entry through synchronizer, pin changed mid-cycle
      set_bits(1'b1, 1'b0, 1'b0, 1'b0);
      pd_i = 1'b0; stop_n_i = 1'b1;
      step(16);
      #6 stop_n_i = 1'b0;
      step(2);
      chk_lanes("R5", 0);
      step(2);
      chk_lanes("R5", 1);
      chk("R5", "lvl parked", int'(lvl_o), 7);

      // R6: resume latency RL+3 edges, first level high
      stop_n_i = 1'b1;
      step(RL + 2);
      chk_lanes("R6", 1);
      step(1);
      chk_lanes("R6", 0);
      chk("R6", "first lvl", int'(lvl_o[0]), 1);
      step(1);
      chk("R6", "second lvl", int'(lvl_o[0]), 0);

      // R7 / R9 / R10: power-down entry
      step(5);
      pd_i = 1'b1;
      step(2);
      chk_lanes("R7", 0);
      chk("R9", "se_low early", int'(se_low_o), 0);
      step(1);
      chk_lanes("R7", 2);
      chk("R7", "lvl", int'(lvl_o), 0);
      chk("R7", "osc_off drain", int'(osc_off_o), 0);
      chk("R9", "se_low", int'(se_low_o), 1);
      chk("R10", "dot park", int'(dot_mode_o), 2);
      dot_pd_tri_i = 1'b1; #1;
      chk("R10", "dot float pd", int'(dot_mode_o), 3);
      dot_pd_tri_i = 1'b0;
      step(1);
      chk("R7", "osc_off", int'(osc_off_o), 1);

      // R8: release and stabilization window
      step(3);
      pd_i = 1'b0;
      step(3);
      chk("R8", "osc_off clear", int'(osc_off_o), 0);
      chk_lanes("R8", 2);
      step(SC - 1);
      chk_lanes("R8", 2);
      chk("R9", "se_low warm", int'(se_low_o), 1);
      step(1);
      chk_lanes("R8", 0);
      chk("R9", "se_low done", int'(se_low_o), 0);
      chk("R10", "dot run", int'(dot_mode_o), 0);
      dot_oe_i = 1'b0; #1;
      chk("R10", "dot disabled", int'(dot_mode_o), 3);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule